// File: doc/BRIEF.md
# Prioritised CAN Transmit Buffer Selector

This block decides which of four CAN transmit buffers goes to the protocol engine next, and it runs the life cycle of each buffer. Every buffer has a state, a 3-bit priority and a transmit time. When the engine asks for a frame and no buffer is being sent, the selector takes the Ready buffer with the highest priority whose transmit time the external time base has reached. It marks that buffer as sending and gives the engine a one-cycle start pulse with the buffer index.

The engine then reports the outcome of the attempt. A success stores the current time as the delivery stamp of that buffer. A failure, either a lost arbitration or an error, returns the buffer to Ready, so it can be tried again, until a retry limit is used up. A host sets buffers ready, empties them, aborts them, writes their transmit times and writes the packed priority register. Frame storage, serialisation and bus arbitration are outside this block.

Top module: `can_txb_select`

## Requirements
- R1: After reset every buffer is Empty and `tx_start` is 0.
- R2: A write to `prio_wdata` loads the priority of buffer n from bits 4n+2..4n, and bit 4n+3 is ignored. Among the eligible buffers, the one with the numerically highest priority is selected.
- R3: When eligible buffers share the highest priority, the one with the lowest index is selected.
- R4: A Ready buffer is not selected while `time_now` is below its transmit time, and it becomes selectable once `time_now` is equal to or greater than that time. A transmit time that is due earlier gives no precedence over a higher priority. A transmit time of 0 (the reset value) is due at once.
- R5: With `eng_req` high and no buffer Sending, a selection makes `tx_start` high for exactly one cycle, with `tx_idx` holding the chosen buffer, and puts that buffer in Sending. While a buffer is Sending, no new start is issued.
- R6: An `eng_ok` pulse moves the Sending buffer to Done and captures `time_now` as its delivery stamp. The stamp is read on `stamp_time` by setting `stamp_sel` to the buffer index.
- R7: An `eng_fail` pulse returns the Sending buffer to Ready. The RETRY_LIMIT-th consecutive failure since the last set-ready moves it to Failed instead.
- R8: Set-ready is accepted only from Empty, Done, Failed or Aborted, and it clears the failure count. In Ready or Sending it has no effect.
- R9: Abort moves a Ready buffer to Aborted in the next cycle. An abort of the Sending buffer is held until the attempt ends: a failure then leads to Aborted and a success to Done. Abort has no effect in Empty, Done or Failed.
- R10: Set-empty moves a buffer in any state other than Sending to Empty. In Sending it has no effect. If several commands reach one buffer in the same cycle, abort takes precedence over set-empty, and set-empty over set-ready.
- R11: `buf_state` carries 3 bits per buffer, with buffer n in bits 3n+2..3n. The codes are Empty=0, Ready=1, Sending=2, Done=3, Failed=4 and Aborted=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_we | input | 1 | Write strobe for the priority register |
| prio_wdata | input | 16 | Packed priorities, one nibble per buffer |
| cmd_ready | input | 4 | Set-ready command, one bit per buffer |
| cmd_empty | input | 4 | Set-empty command, one bit per buffer |
| cmd_abort | input | 4 | Abort command, one bit per buffer |
| ttime_we | input | 4 | Transmit-time write strobe, one bit per buffer |
| ttime_wdata | input | 64 | Transmit time to be written |
| time_now | input | 64 | External time base |
| eng_req | input | 1 | The engine is ready to take a frame |
| eng_ok | input | 1 | The current attempt succeeded |
| eng_fail | input | 1 | The current attempt lost arbitration or failed with an error |
| tx_start | output | 1 | One-cycle pulse: a buffer was handed to the engine |
| tx_idx | output | 2 | Index of the buffer most recently started |
| buf_state | output | 12 | Packed state codes of all buffers |
| stamp_sel | input | 2 | Buffer whose delivery stamp is shown |
| stamp_time | output | 64 | Delivery stamp of the selected buffer |

## Verification
Every command, priority write and engine outcome is registered once. Its effect therefore shows on `buf_state`, `tx_start` and `tx_idx` right after the next rising edge, and the bench samples these outputs on the falling edge that follows. The bench drives all stimulus on a falling edge, steps exactly one edge, and only then compares. In the cycle after a start pulse it checks that `tx_start` has dropped again, even though `eng_req` is still high. The delivery stamp is read combinationally through `stamp_sel` in the cycle after `eng_ok`, and it must equal the `time_now` that was applied during that edge.

// File: rtl/can_txb_pkg.sv
package can_txb_pkg;
    typedef enum logic [2:0] {
        TXB_EMPTY   = 3'd0,
        TXB_READY   = 3'd1,
        TXB_SENDING = 3'd2,
        TXB_DONE    = 3'd3,
        TXB_FAILED  = 3'd4,
        TXB_ABORTED = 3'd5
    } txb_state_e;
endpackage

// File: rtl/can_txb_slot.sv
module can_txb_slot
    import can_txb_pkg::*;
#(
    parameter int TS_W        = 64,
    parameter int RETRY_LIMIT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_ready,
    input  logic            cmd_empty,
    input  logic            cmd_abort,
    input  logic            time_we,
    input  logic [TS_W-1:0] time_wdata,
    input  logic [TS_W-1:0] time_now,
    input  logic            grant,
    input  logic            end_ok,
    input  logic            end_fail,
    output txb_state_e      state_o,
    output logic            eligible,
    output logic [TS_W-1:0] stamp_o
);
    localparam int TRY_W = $clog2(RETRY_LIMIT + 1);

    typedef struct packed {
        txb_state_e      state;
        logic [TRY_W-1:0] tries;
        logic            abort_pend;
        logic [TS_W-1:0] tx_time;
        logic [TS_W-1:0] stamp;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d   = slot_q;
        eligible = (slot_q.state == TXB_READY) && !cmd_abort && !cmd_empty
                   && (time_now >= slot_q.tx_time);
        if (time_we) slot_d.tx_time = time_wdata;
        case (slot_q.state)
            TXB_SENDING: begin
                if (end_ok) begin
                    slot_d.state      = TXB_DONE;
                    slot_d.stamp      = time_now;
                    slot_d.abort_pend = 1'b0;
                end else if (end_fail) begin
                    slot_d.tries      = slot_q.tries + 1'b1;
                    slot_d.abort_pend = 1'b0;
                    if (slot_q.abort_pend || cmd_abort)
                        slot_d.state = TXB_ABORTED;
                    else if (32'(slot_q.tries) + 1 >= RETRY_LIMIT)
                        slot_d.state = TXB_FAILED;
                    else
                        slot_d.state = TXB_READY;
                end else if (cmd_abort) begin
                    slot_d.abort_pend = 1'b1;
                end
            end
            TXB_READY: begin
                if (cmd_abort)      slot_d.state = TXB_ABORTED;
                else if (cmd_empty) slot_d.state = TXB_EMPTY;
                else if (grant)     slot_d.state = TXB_SENDING;
            end
            default: begin
                if (cmd_abort) begin
                    slot_d.state = slot_q.state;
                end else if (cmd_empty) begin
                    slot_d.state = TXB_EMPTY;
                end else if (cmd_ready) begin
                    slot_d.state = TXB_READY;
                    slot_d.tries = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q.state      <= TXB_EMPTY;
            slot_q.tries      <= '0;
            slot_q.abort_pend <= 1'b0;
            slot_q.tx_time    <= '0;
            slot_q.stamp      <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign state_o = slot_q.state;
    assign stamp_o = slot_q.stamp;

    p_grant_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (slot_q.state == TXB_READY && time_now >= slot_q.tx_time));

    p_done_stamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.state == TXB_SENDING && end_ok)
        |=> (slot_q.state == TXB_DONE && slot_q.stamp == $past(time_now)));

    p_fail_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.state == TXB_SENDING && end_fail && !end_ok && !slot_q.abort_pend
         && !cmd_abort && slot_q.tries == TRY_W'(RETRY_LIMIT - 1))
        |=> slot_q.state == TXB_FAILED);

    p_sending_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.state == TXB_SENDING && !end_ok && !end_fail)
        |=> slot_q.state == TXB_SENDING);

    p_abort_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.state == TXB_READY && cmd_abort) |=> slot_q.state == TXB_ABORTED);
endmodule

// File: rtl/can_txb_pick.sv
module can_txb_pick #(
    parameter int NB     = 4,
    parameter int PRIO_W = 3
) (
    input  logic [NB-1:0]        elig,
    input  logic [NB*PRIO_W-1:0] prio,
    output logic [NB-1:0]        grant,
    output logic                 found,
    output logic [$clog2(NB)-1:0] pick_idx
);
    localparam int IDX_W = $clog2(NB);

    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        found     = 1'b0;
        best_prio = '0;
        pick_idx  = '0;
        for (int i = 0; i < NB; i++) begin
            if (elig[i] && (!found || prio[i*PRIO_W +: PRIO_W] > best_prio)) begin
                found     = 1'b1;
                best_prio = prio[i*PRIO_W +: PRIO_W];
                pick_idx  = IDX_W'(i);
            end
        end
        grant = '0;
        if (found) grant[pick_idx] = 1'b1;
    end
endmodule

// File: rtl/can_txb_select.sv
module can_txb_select
    import can_txb_pkg::*;
#(
    parameter int NB          = 4,
    parameter int PRIO_W      = 3,
    parameter int NIB_W       = 4,
    parameter int TS_W        = 64,
    parameter int RETRY_LIMIT = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prio_we,
    input  logic [NB*NIB_W-1:0]     prio_wdata,
    input  logic [NB-1:0]           cmd_ready,
    input  logic [NB-1:0]           cmd_empty,
    input  logic [NB-1:0]           cmd_abort,
    input  logic [NB-1:0]           ttime_we,
    input  logic [TS_W-1:0]         ttime_wdata,
    input  logic [TS_W-1:0]         time_now,
    input  logic                    eng_req,
    input  logic                    eng_ok,
    input  logic                    eng_fail,
    output logic                    tx_start,
    output logic [$clog2(NB)-1:0]   tx_idx,
    output logic [NB*3-1:0]         buf_state,
    input  logic [$clog2(NB)-1:0]   stamp_sel,
    output logic [TS_W-1:0]         stamp_time
);
    localparam int IDX_W = $clog2(NB);

    typedef struct packed {
        logic [NB*PRIO_W-1:0] prio;
        logic                 start;
        logic [IDX_W-1:0]     idx;
    } top_t;

    top_t top_d, top_q;

    txb_state_e       states  [NB];
    logic [TS_W-1:0]  stamps  [NB];
    logic [NB-1:0]    elig, grant, sending;
    logic             found, busy, go;
    logic [IDX_W-1:0] pick_idx;

    for (genvar g = 0; g < NB; g++) begin : g_slot
        can_txb_slot #(.TS_W(TS_W), .RETRY_LIMIT(RETRY_LIMIT)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_ready  (cmd_ready[g]),
            .cmd_empty  (cmd_empty[g]),
            .cmd_abort  (cmd_abort[g]),
            .time_we    (ttime_we[g]),
            .time_wdata (ttime_wdata),
            .time_now   (time_now),
            .grant      (grant[g]),
            .end_ok     (eng_ok && sending[g]),
            .end_fail   (eng_fail && sending[g]),
            .state_o    (states[g]),
            .eligible   (elig[g]),
            .stamp_o    (stamps[g])
        );
        assign sending[g]           = (states[g] == TXB_SENDING);
        assign buf_state[g*3 +: 3]  = states[g];
    end

    assign busy = |sending;
    assign go   = eng_req && !busy;

    can_txb_pick #(.NB(NB), .PRIO_W(PRIO_W)) u_pick (
        .elig     (elig & {NB{go}}),
        .prio     (top_q.prio),
        .grant    (grant),
        .found    (found),
        .pick_idx (pick_idx)
    );

    always_comb begin
        top_d       = top_q;
        top_d.start = found;
        if (found) top_d.idx = pick_idx;
        if (prio_we) begin
            for (int i = 0; i < NB; i++)
                top_d.prio[i*PRIO_W +: PRIO_W] = prio_wdata[i*NIB_W +: PRIO_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign tx_start   = top_q.start;
    assign tx_idx     = top_q.idx;
    assign stamp_time = stamps[stamp_sel];

    p_start_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> sending[tx_idx]);

    p_no_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !tx_start);

    p_single_sender_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sending) <= 1);
endmodule

// File: tb/can_txb_select_test.sv
module can_txb_select_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prio_we = 1'b0;
    logic [15:0] prio_wdata = '0;
    logic [3:0]  cmd_ready = '0, cmd_empty = '0, cmd_abort = '0, ttime_we = '0;
    logic [63:0] ttime_wdata = '0, time_now = '0;
    logic        eng_req = 1'b0, eng_ok = 1'b0, eng_fail = 1'b0;
    logic        tx_start;
    logic [1:0]  tx_idx, stamp_sel = '0;
    logic [11:0] buf_state;
    logic [63:0] stamp_time;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    localparam logic [2:0] S_EMP = 3'd0, S_RDY = 3'd1, S_SND = 3'd2,
                           S_DON = 3'd3, S_FAI = 3'd4, S_ABT = 3'd5;

    always #2 clk = ~clk;

    can_txb_select uut (
        .clk(clk), .rst_n(rst_n), .prio_we(prio_we), .prio_wdata(prio_wdata),
        .cmd_ready(cmd_ready), .cmd_empty(cmd_empty), .cmd_abort(cmd_abort),
        .ttime_we(ttime_we), .ttime_wdata(ttime_wdata), .time_now(time_now),
        .eng_req(eng_req), .eng_ok(eng_ok), .eng_fail(eng_fail),
        .tx_start(tx_start), .tx_idx(tx_idx), .buf_state(buf_state),
        .stamp_sel(stamp_sel), .stamp_time(stamp_time)
    );

    function automatic logic [2:0] st(input int i);
        return buf_state[i*3 +: 3];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset;
        prio_we = 0; cmd_ready = 0; cmd_empty = 0; cmd_abort = 0; ttime_we = 0;
        eng_req = 0; eng_ok = 0; eng_fail = 0; time_now = 0; stamp_sel = 0;
        rst_n = 0;
        tick; tick;
        rst_n = 1;
    endtask

    task automatic set_prio(input logic [15:0] v);
        prio_wdata = v; prio_we = 1; tick; prio_we = 0;
    endtask

    task automatic ready(input logic [3:0] m);
        cmd_ready = m; tick; cmd_ready = 0;
    endtask

    task automatic req;
        eng_req = 1; tick; eng_req = 0;
    endtask

    task automatic ok_at(input logic [63:0] t);
        time_now = t; eng_ok = 1; tick; eng_ok = 0;
    endtask

    task automatic fail_once;
        eng_fail = 1; tick; eng_fail = 0;
    endtask

    task automatic t_reset;
        do_reset;
        chk("R1 states", buf_state, 12'h000);
        chk("R1 tx_start", tx_start, 0);
    endtask

    // Priorities buf0=2 buf1=5 buf2=7 buf3=1 (nibble 9 checks bit 3 ignored).
    task automatic t_priority;
        do_reset;
        set_prio(16'h9752);
        ready(4'b1111);
        chk("R11 all ready", buf_state, {S_RDY, S_RDY, S_RDY, S_RDY});
        eng_req = 1; tick;
        chk("R5 start pulse", tx_start, 1);
        chk("R2 highest first", tx_idx, 2);
        chk("R5 sending", st(2), S_SND);
        tick;
        chk("R5 no second start", tx_start, 0);
        eng_req = 0;
        ok_at(64'd100);
        stamp_sel = 2;
        chk("R6 done", st(2), S_DON);
        #0 chk("R6 stamp", stamp_time, 64'd100);
        req; chk("R2 second", tx_idx, 1); ok_at(64'd200);
        req; chk("R2 third", tx_idx, 0); ok_at(64'd300);
        req; chk("R2 bit3 ignored", tx_idx, 3); ok_at(64'd400);
        stamp_sel = 1;
        #0 chk("R6 stamp buf1", stamp_time, 64'd200);
    endtask

    task automatic t_tie;
        do_reset;
        set_prio(16'h3333);
        ready(4'b1010);
        req;
        chk("R3 tie lowest index", tx_idx, 1);
        ok_at(64'd5);
        req;
        chk("R3 then next", tx_idx, 3);
    endtask

    task automatic t_time;
        do_reset;
        set_prio(16'h6471);  // buf0=1 buf1=7 buf2=4 buf3=6
        ttime_wdata = 64'd500; ttime_we = 4'b0010; tick; ttime_we = 0;
        time_now = 64'd100;
        ready(4'b0011);
        req;
        chk("R4 not-due skipped", tx_idx, 0);
        ok_at(64'd100);
        req;
        chk("R4 no start before time", tx_start, 0);
        chk("R4 still ready", st(1), S_RDY);
        time_now = 64'd499; req;
        chk("R4 one short", tx_start, 0);
        time_now = 64'd500; req;
        chk("R4 due start", tx_start, 1);
        chk("R4 due idx", tx_idx, 1);
        ok_at(64'd501);
        ttime_wdata = 64'd10;  ttime_we = 4'b0100; tick;
        ttime_wdata = 64'd400; ttime_we = 4'b1000; tick; ttime_we = 0;
        time_now = 64'd450;
        ready(4'b1100);
        req;
        chk("R4 time gives no precedence", tx_idx, 3);
    endtask

    task automatic t_retry;
        do_reset;
        ready(4'b0001);
        req; fail_once;
        chk("R7 fail 1 ready", st(0), S_RDY);
        req; fail_once;
        chk("R7 fail 2 ready", st(0), S_RDY);
        req; fail_once;
        chk("R7 limit failed", st(0), S_FAI);
        ready(4'b0001);
        chk("R8 ready from failed", st(0), S_RDY);
        req; fail_once;
        chk("R8 count cleared", st(0), S_RDY);
    endtask

    task automatic t_cmds;
        do_reset;
        ready(4'b0011);
        ready(4'b0001);
        chk("R8 ready ignored in ready", st(0), S_RDY);
        req;
        chk("R5 buf0 sending", st(0), S_SND);
        ready(4'b0001);
        chk("R8 ready ignored in sending", st(0), S_SND);
        cmd_empty = 4'b0001; tick; cmd_empty = 0;
        chk("R10 empty ignored in sending", st(0), S_SND);
        cmd_empty = 4'b0010; tick; cmd_empty = 0;
        chk("R10 empty from ready", st(1), S_EMP);
        cmd_abort = 4'b0100; tick; cmd_abort = 0;
        chk("R9 abort ignored in empty", st(2), S_EMP);
        cmd_abort = 4'b0010; cmd_empty = 4'b0010; cmd_ready = 4'b0010; tick;
        cmd_abort = 0; cmd_empty = 0; cmd_ready = 0;
        chk("R10 command precedence", st(1), S_EMP);
    endtask

    task automatic t_abort;
        do_reset;
        ready(4'b0011);
        cmd_abort = 4'b0010; tick; cmd_abort = 0;
        chk("R9 abort ready", st(1), S_ABT);
        req;
        chk("R9 buf0 start", tx_idx, 0);
        ok_at(64'd7);
        req;
        chk("R9 aborted not selected", tx_start, 0);
        ready(4'b0001);
        req;
        cmd_abort = 4'b0001; tick; cmd_abort = 0;
        chk("R9 abort held while sending", st(0), S_SND);
        fail_once;
        chk("R9 fail after abort", st(0), S_ABT);
        ready(4'b0001);
        req;
        cmd_abort = 4'b0001; tick; cmd_abort = 0;
        ok_at(64'd9);
        chk("R9 ok after abort", st(0), S_DON);
    endtask

    initial begin
        t_reset;
        t_priority;
        t_tie;
        t_time;
        t_retry;
        t_cmds;
        t_abort;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule